// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block holds the control register that sits in front of an on-chip flash array and decides when the program/erase supply may be applied. Software arms a set of programming latches. The next array write after arming has its address and data captured. Only after that capture may software switch on the program/erase voltage. Once the voltage is on, the other control bits are frozen. The only thing software can still do is switch the voltage off again.

The block also steers array reads according to the control state. A read can return the addressed array word, the word held in the programming latches, or nothing at all. When a read is blocked, the block still returns a valid strobe with all-zero data. A supply-level input stops the latches from being armed unless the programming supply is at its high level.

Top module: `flash_pe_guard`

## Requirements
- R1: After reset, all four control bits read 0, the voltage enable is 0, the capture flag is 0 and no read result is valid.
- R2: The control word has bit 0 = voltage on, bit 1 = latch arm, bit 2 = erase select and bit 3 = boot guard. While arm is 1 and the capture flag is 0, an array write stores its address and data on `prog_addr`/`prog_data` and sets the capture flag in the next cycle.
- R3: A register write can turn the voltage on only if arm was already 1, the capture flag is 1, and the same write keeps arm at 1. Otherwise bit 0 reads back 0 after the write.
- R4: While bit 0 is 1, a register write changes only bit 0, and bits 1 to 3 keep their values. While bit 0 is 0, the erase and boot bits take the written value.
- R5: An array read returns its result, with `rd_valid` high, in the cycle after `arr_rd`. The result is selected as follows:
  - voltage on: the read is ignored and returns 0;
  - voltage off, arm 1, erase 0: the result is the captured `prog_data`;
  - otherwise: the result is `mem_rdata`.
- R6: Arm can be changed from 0 to 1 only while `vpp_high` is 1. A write of arm while the supply is low leaves arm at 0.
- R7: Once the capture flag is set, further array writes do not change `prog_addr` or `prog_data`. The flag returns to 0 when arm goes from 1 to 0.
- R8: `pe_vpp_en` equals control bit 0 at all times. It drops in the cycle after the write that clears bit 0.
- R9: A single write that sets bit 0 and clears arm leaves both bits at 0, so no programming or erasure takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control word to write |
| reg_rdata | output | 4 | Current control word |
| vpp_high | input | 1 | 1 when the programming supply is at high level |
| arr_wr | input | 1 | Array write strobe |
| arr_rd | input | 1 | Array read strobe |
| arr_addr | input | AW | Array address for read or write |
| arr_wdata | input | DW | Array write data |
| mem_rdata | input | DW | Data of the addressed array word |
| prog_addr | output | AW | Captured programming address |
| prog_data | output | DW | Captured programming data |
| prog_loaded | output | 1 | Capture flag |
| pe_vpp_en | output | 1 | Program/erase voltage enable |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | DW | Read result |

## Verification
The bench tries to switch on the voltage in the wrong order, both before any capture and in a write that also drops arm. A design with a loose interlock would raise `pe_vpp_en` in those cases. It writes to the frozen bits while the voltage is on, and it sends a second array write after a capture. A design that lets either through would change the read-back word or the captured address. All four read-steering paths are checked with distinct data, so a swapped selection shows up as a wrong value. Arming with the supply low checks that the level gate is not skipped.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef struct packed {
    logic boot;
    logic erase;
    logic arm;
    logic hv;
  } pe_ctrl_t;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_LATCH = 2'd1,
    RD_BLOCK = 2'd2
  } rd_mode_t;

  localparam int CTRL_W = 4;
endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pe_ctrl_t wdata,
  input  logic     vpp_high,
  input  logic     loaded,
  output pe_ctrl_t ctrl_q,
  output logic     arm_fall
);
  pe_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      if (ctrl_q.hv) begin
        // frozen: only the voltage bit may move
        ctrl_d.hv = wdata.hv;
      end else begin
        ctrl_d.arm   = wdata.arm & (ctrl_q.arm | vpp_high);
        ctrl_d.erase = wdata.erase;
        ctrl_d.boot  = wdata.boot;
        ctrl_d.hv    = wdata.hv & wdata.arm & ctrl_q.arm & loaded;
      end
    end
  end

  assign arm_fall = ctrl_q.arm & ~ctrl_d.arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  AST_HV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.hv) |-> ($past(ctrl_q.arm) && $past(loaded) && ctrl_q.arm)); // R3
  AST_FROZEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q.hv) |-> ($stable(ctrl_q.arm) && $stable(ctrl_q.erase) && $stable(ctrl_q.boot))); // R4
  AST_ARM_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.arm) |-> $past(vpp_high)); // R6
endmodule

// File: rtl/flash_pe_latch.sv
module flash_pe_latch #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          arm_fall,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          loaded_q
);
  logic capture;
  logic loaded_d;

  assign capture = wr_en & arm & ~loaded_q & ~arm_fall;

  always_comb begin
    loaded_d = loaded_q;
    if (arm_fall)     loaded_d = 1'b0;
    else if (capture) loaded_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr;
      data_q <= data;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loaded_q) && loaded_q) |-> ($stable(addr_q) && $stable(data_q))); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_fall) |-> !loaded_q); // R7
endmodule

// File: rtl/flash_pe_rdsteer.sv
module flash_pe_rdsteer
  import flash_pe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          hv,
  input  logic          arm,
  input  logic          erase,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] latch_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  rd_mode_t      mode;
  logic [DW-1:0] data_d;

  always_comb begin
    if (hv)                 mode = RD_BLOCK;
    else if (arm && !erase) mode = RD_LATCH;
    else                    mode = RD_ARRAY;
  end

  always_comb begin
    case (mode)
      RD_BLOCK: data_d = '0;
      RD_LATCH: data_d = latch_data;
      default:  data_d = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= data_d;
    end
  end

  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && hv) |-> (rd_valid && rd_data == '0)); // R5
  AST_LATCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !hv && arm && !erase) |-> (rd_data == $past(latch_data))); // R5
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import flash_pe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              vpp_high,
  input  logic              arr_wr,
  input  logic              arr_rd,
  input  logic [AW-1:0]     arr_addr,
  input  logic [DW-1:0]     arr_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     prog_addr,
  output logic [DW-1:0]     prog_data,
  output logic              prog_loaded,
  output logic              pe_vpp_en,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  pe_ctrl_t ctrl_q;
  logic     arm_fall;

  flash_pe_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wdata    (pe_ctrl_t'(reg_wdata)),
    .vpp_high (vpp_high),
    .loaded   (prog_loaded),
    .ctrl_q   (ctrl_q),
    .arm_fall (arm_fall)
  );

  flash_pe_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (ctrl_q.arm),
    .arm_fall (arm_fall),
    .wr_en    (arr_wr),
    .addr     (arr_addr),
    .data     (arr_wdata),
    .addr_q   (prog_addr),
    .data_q   (prog_data),
    .loaded_q (prog_loaded)
  );

  flash_pe_rdsteer #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (arr_rd),
    .hv         (ctrl_q.hv),
    .arm        (ctrl_q.arm),
    .erase      (ctrl_q.erase),
    .mem_rdata  (mem_rdata),
    .latch_data (prog_data),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign reg_rdata = ctrl_q;
  assign pe_vpp_en = ctrl_q.hv;

  AST_VPP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pe_vpp_en == reg_rdata[0]); // R8
endmodule

// File: tb/flash_pe_guard_bench.sv
`timescale 1ns/1ps
module flash_pe_guard_bench;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [3:0]    reg_wdata;
  logic [3:0]    reg_rdata;
  logic          vpp_high;
  logic          arr_wr, arr_rd;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, mem_rdata;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          prog_loaded, pe_vpp_en, rd_valid;
  logic [DW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = {4'h0, arr_addr} ^ 16'h5A5A;

  flash_pe_guard #(.AW(AW), .DW(DW)) u_flash_pe_guard (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vpp_high(vpp_high), .arr_wr(arr_wr),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .mem_rdata(mem_rdata), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_loaded(prog_loaded), .pe_vpp_en(pe_vpp_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic arr_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
    @(negedge clk);
    arr_wr = 1'b0;
  endtask

  task automatic arr_read(logic [AW-1:0] a, string req, logic [DW-1:0] exp);
    @(negedge clk);
    arr_rd = 1'b1; arr_addr = a;
    @(negedge clk);
    arr_rd = 1'b0;
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    check("R1 ctrl", 32'(reg_rdata), 32'h0);
    check("R1 vpp", 32'(pe_vpp_en), 32'h0);
    check("R1 flag", 32'(prog_loaded), 32'h0);
    check("R1 valid", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_arm_gate();
    vpp_high = 1'b0;
    reg_write(4'h2);
    check("R6 arm blocked", 32'(reg_rdata), 32'h0);
    reg_write(4'h1);
    check("R3 hv without arm", 32'(reg_rdata), 32'h0);
    vpp_high = 1'b1;
    reg_write(4'h2);
    check("R6 arm set", 32'(reg_rdata), 32'h2);
  endtask

  task automatic t_order_and_capture();
    reg_write(4'h3);
    check("R3 hv before capture", 32'(reg_rdata), 32'h2);
    check("R8 vpp off", 32'(pe_vpp_en), 32'h0);
    arr_write(12'h123, 16'hBEEF);
    check("R2 addr", 32'(prog_addr), 32'h123);
    check("R2 data", 32'(prog_data), 32'hBEEF);
    check("R2 flag", 32'(prog_loaded), 32'h1);
    arr_write(12'h456, 16'h1111);
    check("R7 addr held", 32'(prog_addr), 32'h123);
    check("R7 data held", 32'(prog_data), 32'hBEEF);
  endtask

  task automatic t_reads_and_freeze();
    arr_read(12'h040, "R5 latch read", 16'hBEEF);
    reg_write(4'h6);
    arr_read(12'h040, "R5 erase read", 16'h5A1A);
    reg_write(4'h7);
    check("R3 hv on", 32'(reg_rdata), 32'h7);
    check("R8 vpp on", 32'(pe_vpp_en), 32'h1);
    arr_read(12'h040, "R5 blocked read", 16'h0000);
    reg_write(4'h9);
    check("R4 frozen", 32'(reg_rdata), 32'h7);
    reg_write(4'h6);
    check("R4 hv cleared only", 32'(reg_rdata), 32'h6);
    check("R8 vpp drops", 32'(pe_vpp_en), 32'h0);
    check("R7 flag kept", 32'(prog_loaded), 32'h1);
    reg_write(4'h0);
    check("R7 flag cleared", 32'(prog_loaded), 32'h0);
    arr_read(12'h0AB, "R5 normal read", 16'h5AF1);
  endtask

  task automatic t_set_and_drop();
    reg_write(4'h2);
    arr_write(12'h010, 16'h2222);
    check("R9 flag", 32'(prog_loaded), 32'h1);
    reg_write(4'h1);
    check("R9 ctrl", 32'(reg_rdata), 32'h0);
    check("R9 vpp", 32'(pe_vpp_en), 32'h0);
    check("R9 flag drop", 32'(prog_loaded), 32'h0);
    reg_write(4'h8);
    check("R4 boot writable", 32'(reg_rdata), 32'h8);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; vpp_high = 1'b0;
    arr_wr = 1'b0; arr_rd = 1'b0; arr_addr = '0; arr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_gate();
    t_order_and_capture();
    t_reads_and_freeze();
    t_set_and_drop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule